// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a cycle-level model of a non-volatile static RAM. It holds two synchronous arrays of equal size: a working SRAM that the host reads and writes like any static RAM, and a shadow array that stands in for the non-volatile cells. The shadow array is never reachable from the host pins directly. Data moves between the two arrays only through two whole-array transfers. A save copies the SRAM into the shadow. A restore first zeroes the SRAM and then loads it from the shadow.

Software starts a transfer without any extra pin. The host performs six ordinary reads at a fixed run of addresses. The first five addresses are a parameter table. The sixth address selects the operation: one value starts a save and another starts a restore. Any write, and any read off the expected address, breaks the run, so that normal traffic cannot start a transfer by accident. A restore also runs by itself when reset is released, in the same way that a real part reloads at power-up. During a transfer, `busy` is high, host writes and reads have no effect, and the data bus stays released. The transfer walks one address per clock. Its length is padded to a parameterised cycle count.

Each clock edge on which `ce_n` is low counts as one host access. Accesses are decoded from the three active-low strobes.

Top module: `nvs_ctrl`

## Requirements
- R1: On a clock edge with `ce_n`=0, `we_n`=1, `oe_n`=0 and `busy`=0, the block captures the SRAM word at `addr`. After that edge, `dout` holds the word and `dout_en`=1. On an edge with `ce_n`=0, `we_n`=0 and `busy`=0, the block writes `din` into the SRAM at `addr`.
- R2: An access with `oe_n`=1 (an internal read), a write access, and a deselected cycle (`ce_n`=1) all leave `dout_en`=0 after the edge. A deselected cycle changes no SRAM word.
- R3: The unlock run is six selected reads on consecutive accesses. Reads one to five use the prefix table, which defaults to 0x4E, 0xB1, 0x83, 0x7C, 0x3F. The sixth read at 0xF0 starts a save, and the sixth read at 0x0F starts a restore. `busy` is 1 right after the edge that takes the sixth read, and the bus is not driven for that read.
- R4: A write, or a read whose address differs from the expected entry, clears the unlock progress, so the run must begin again. A differing read that equals the first prefix entry counts as a new first step. A sixth read at any address other than the two selectors starts nothing. Deselected cycles leave the progress unchanged.
- R5: A save copies every SRAM word into the shadow array. `busy` stays 1 for exactly max(STORE_CYCLES, DEPTH+1) clock edges, counted from the edge that starts it. With the defaults this is 300.
- R6: A restore zeroes the whole SRAM and then loads every word from the shadow array. `busy` stays 1 for exactly max(RECALL_CYCLES, 2·DEPTH+1) edges, which is 600 with the defaults. The shadow array is left unchanged, so repeated restores give the same image.
- R7: While `rst_n`=0, `busy`=1 and `dout_en`=0. When reset is released, a restore starts, and `busy` falls after the RECALL span of edges.
- R8: While `busy`=1, host writes change no SRAM word, reads leave `dout_en`=0, and no unlock progress is made.
- R9: `standby`=1 exactly when `ce_n`=1 and `busy`=0. Raising `ce_n` during a transfer does not give standby until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; its release starts a restore |
| ce_n | input | 1 | Active-low chip select; low marks an access this cycle |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, registered |
| dout_en | output | 1 | High when `dout` should be driven onto the bus |
| busy | output | 1 | High for the whole of a save or restore |
| standby | output | 1 | Deselected with no transfer running |

## Verification
The assertions assume that each rising edge with `ce_n` low is exactly one host access. They also assume that the strobes and the address are stable across that edge. The bench changes every input one time unit after a rising edge and samples the outputs at that same point, so each access is seen by exactly one edge. The assertions do not depend on the content of the arrays, because the shadow array has no reset. For that reason the bench checks data only after it has written the whole SRAM and saved it.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // Length of the unlock prefix; the selector read follows it.
  localparam int PREFIX_LEN = 5;

  typedef enum logic [2:0] {
    XS_IDLE   = 3'd0,
    XS_STORE  = 3'd1,
    XS_CLEAR  = 3'd2,
    XS_LOAD   = 3'd3,
    XS_SETTLE = 3'd4
  } xfer_state_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_STORE = 2'd1,
    OP_CLEAR = 2'd2,
    OP_LOAD  = 2'd3
  } xfer_op_e;

  // Edges for which busy is high: the requested duration, stretched so that
  // every walking pass plus one settle cycle fits inside it.
  function automatic int busy_span(input int dur, input int passes, input int depth);
    int walk;
    walk = passes * depth + 1;
    return (dur > walk) ? dur : walk;
  endfunction

  // Unlock progress after one selected read.
  function automatic logic [2:0] step_after_read(input logic hit_expected,
                                                 input logic hit_first,
                                                 input logic [2:0] cur);
    if (hit_expected) return cur + 3'd1;
    return hit_first ? 3'd1 : 3'd0;
  endfunction

endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock
  import nvs_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [PREFIX_LEN-1:0][AW-1:0] PREFIX = '0,
  parameter logic [AW-1:0] SAVE_SEL = '0,
  parameter logic [AW-1:0] LOAD_SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [AW-1:0] addr,
  output logic          go_save,
  output logic          go_load
);

  logic [2:0] stage_q, stage_d;
  logic [2:0] pidx;
  logic       at_select;
  logic       hit_expected;
  logic       hit_first;

  assign at_select    = (stage_q == 3'(PREFIX_LEN));
  assign pidx         = at_select ? 3'd0 : stage_q;
  assign hit_expected = !at_select && (addr == PREFIX[pidx]);
  assign hit_first    = (addr == PREFIX[0]);

  assign go_save = enable && acc_rd && at_select && (addr == SAVE_SEL);
  assign go_load = enable && acc_rd && at_select && (addr == LOAD_SEL);

  always_comb begin
    stage_d = stage_q;
    if (!enable || acc_wr || go_save || go_load) begin
      stage_d = 3'd0;
    end else if (acc_rd) begin
      stage_d = step_after_read(hit_expected, hit_first, stage_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 3'd0;
    else        stage_q <= stage_d;
  end

  // R4: a write in the middle of a run throws the progress away
  a_r4_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && acc_wr) |=> (stage_q == 3'd0));

  // R8: no progress is kept while a transfer holds the block
  a_r8_no_progress_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> (stage_q == 3'd0));

endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
  import nvs_pkg::*;
#(
  parameter int AW            = 8,
  parameter int STORE_CYCLES  = 300,
  parameter int RECALL_CYCLES = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_save,
  input  logic          go_load,
  output logic          busy,
  output xfer_op_e      op,
  output logic [AW-1:0] ptr
);

  localparam int DEPTH    = 1 << AW;
  localparam int S_SPAN   = busy_span(STORE_CYCLES, 1, DEPTH);
  localparam int R_SPAN   = busy_span(RECALL_CYCLES, 2, DEPTH);
  localparam int MAX_SPAN = (S_SPAN > R_SPAN) ? S_SPAN : R_SPAN;
  localparam int TW       = $clog2(MAX_SPAN) + 1;
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [TW-1:0] S_LIM  = TW'(S_SPAN - 1);
  localparam logic [TW-1:0] R_LIM  = TW'(R_SPAN - 1);

  xfer_state_e   state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [TW-1:0] tick_q, tick_d;
  logic [TW-1:0] lim_q, lim_d;
  logic          pass_end;

  assign pass_end = (ptr_q == LAST);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    tick_d  = tick_q + 1'b1;
    lim_d   = lim_q;
    unique case (state_q)
      XS_IDLE: begin
        tick_d = '0;
        ptr_d  = '0;
        if (go_save) begin
          state_d = XS_STORE;
          lim_d   = S_LIM;
        end else if (go_load) begin
          state_d = XS_CLEAR;
          lim_d   = R_LIM;
        end
      end
      XS_STORE: begin
        ptr_d = ptr_q + 1'b1;
        if (pass_end) state_d = XS_SETTLE;
      end
      XS_CLEAR: begin
        ptr_d = ptr_q + 1'b1;
        if (pass_end) state_d = XS_LOAD;
      end
      XS_LOAD: begin
        ptr_d = ptr_q + 1'b1;
        if (pass_end) state_d = XS_SETTLE;
      end
      XS_SETTLE: begin
        if (tick_q == lim_q) state_d = XS_IDLE;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  // Reset lands in the clearing pass: the power-up restore.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_CLEAR;
      ptr_q   <= '0;
      tick_q  <= '0;
      lim_q   <= R_LIM;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      tick_q  <= tick_d;
      lim_q   <= lim_d;
    end
  end

  always_comb begin
    unique case (state_q)
      XS_STORE: op = OP_STORE;
      XS_CLEAR: op = OP_CLEAR;
      XS_LOAD:  op = OP_LOAD;
      default:  op = OP_NONE;
    endcase
  end

  assign busy = (state_q != XS_IDLE);
  assign ptr  = ptr_q;

  // R3: a save request from idle starts the copy pass at the next edge
  a_r3_save_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (go_save && state_q == XS_IDLE) |=> (state_q == XS_STORE && ptr_q == '0));

  // R5: the save pass walks one address per clock
  a_r5_store_walks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_STORE && !pass_end) |=> (state_q == XS_STORE && ptr_q == $past(ptr_q) + 1'b1));

  // R6: loading is entered only right after a complete clearing pass
  a_r6_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == XS_LOAD) |-> ($past(state_q) == XS_CLEAR && $past(ptr_q) == LAST));

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
  import nvs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  xfer_op_e      op,
  input  logic [AW-1:0] ptr
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] work_mem   [DEPTH];
  logic [DW-1:0] shadow_mem [DEPTH];

  // Working array: host port, plus the clear and load passes of a restore.
  always_ff @(posedge clk) begin
    if (host_we) begin
      work_mem[host_addr] <= host_wdata;
    end else if (op == OP_CLEAR) begin
      work_mem[ptr] <= '0;
    end else if (op == OP_LOAD) begin
      work_mem[ptr] <= shadow_mem[ptr];
    end
    if (host_re) host_rdata <= work_mem[host_addr];
  end

  // Shadow array: written only by the save pass.
  always_ff @(posedge clk) begin
    if (op == OP_STORE) shadow_mem[ptr] <= work_mem[ptr];
  end

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 8,
  parameter int STORE_CYCLES  = 300,
  parameter int RECALL_CYCLES = 600,
  parameter logic [PREFIX_LEN-1:0][AW-1:0] UNLOCK_PREFIX =
    {AW'('h3F), AW'('h7C), AW'('h83), AW'('hB1), AW'('h4E)},
  parameter logic [AW-1:0] SAVE_SEL = AW'('hF0),
  parameter logic [AW-1:0] LOAD_SEL = AW'('h0F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy,
  output logic          standby
);

  logic     sel;
  logic     acc_rd;
  logic     acc_wr;
  logic     go_save;
  logic     go_load;
  logic     host_we;
  logic     host_re;
  logic     drive_d;
  xfer_op_e op;
  logic [AW-1:0] ptr;

  // Host decode: accesses count only when no transfer owns the arrays.
  assign sel     = !ce_n && !busy;
  assign acc_rd  = sel && we_n;
  assign acc_wr  = sel && !we_n;
  assign host_we = acc_wr;
  assign host_re = acc_rd;
  assign drive_d = acc_rd && !oe_n && !go_save && !go_load;

  nvs_unlock #(
    .AW       (AW),
    .PREFIX   (UNLOCK_PREFIX),
    .SAVE_SEL (SAVE_SEL),
    .LOAD_SEL (LOAD_SEL)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (!busy),
    .acc_rd  (acc_rd),
    .acc_wr  (acc_wr),
    .addr    (addr),
    .go_save (go_save),
    .go_load (go_load)
  );

  nvs_xfer_fsm #(
    .AW            (AW),
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_save (go_save),
    .go_load (go_load),
    .busy    (busy),
    .op      (op),
    .ptr     (ptr)
  );

  nvs_arrays #(
    .AW (AW),
    .DW (DW)
  ) u_arrays (
    .clk        (clk),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (addr),
    .host_wdata (din),
    .host_rdata (dout),
    .op         (op),
    .ptr        (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_en <= 1'b0;
    else        dout_en <= drive_d;
  end

  assign standby = ce_n && !busy;

  // R8: the bus stays released for the whole of a transfer
  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);

  // R8: a transfer pass and a host write never meet at the working array
  a_r8_no_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE) |-> !host_we);

  // R3: a trigger read never turns the bus on
  a_r3_trigger_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go_save || go_load) |=> (busy && !dout_en));

endmodule

// File: tb/tb_nvs_ctrl.sv
`timescale 1ns/1ps
module tb_nvs_ctrl;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int SAVE_SPAN = 300;  // max(300, 257)
  localparam int LOAD_SPAN = 600;  // max(600, 513)
  localparam logic [7:0] PFX [5] = '{8'h4E, 8'hB1, 8'h83, 8'h7C, 8'h3F};
  localparam logic [7:0] SAVE_A = 8'hF0;
  localparam logic [7:0] LOAD_A = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy, standby;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nvs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .standby(standby)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: inputs set just after an edge, outputs read just after the next.
  task automatic cyc(input logic c, input logic w, input logic o,
                     input logic [7:0] a, input logic [7:0] d);
    ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, 8'(a), d);
  endtask

  task automatic rd(input int a);
    cyc(1'b0, 1'b1, 1'b0, 8'(a), 8'h00);
  endtask

  task automatic sweep(input bit inverted, input string req);
    int bad = 0;
    int first_act = 0, first_exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] e;
      e = inverted ? ~pat(a) : pat(a);
      rd(a);
      if (!dout_en || dout !== e) begin
        if (bad == 0) begin first_act = int'(dout); first_exp = int'(e); end
        bad++;
      end
    end
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    check(bad == 0, req, first_act, first_exp);
  endtask

  task automatic fill(input bit inverted);
    for (int a = 0; a < DEPTH; a++) wr(a, inverted ? ~pat(a) : pat(a));
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
  endtask

  task automatic unlock(input logic [7:0] sel);
    for (int i = 0; i < 5; i++) rd(PFX[i]);
    rd(sel);
  endtask

  // Counts edges until busy falls; optionally hammers writes meanwhile.
  task automatic wait_idle(input bit hammer, output int n, output int leaks);
    n = 0; leaks = 0;
    while (busy && n < 5000) begin
      if (hammer) wr(n % DEPTH, 8'hEE);
      else cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
      if (dout_en) leaks++;
      if (busy && !hammer && standby) leaks++;
      n++;
    end
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
  endtask

  task automatic t_reset();
    int n, leaks;
    @(posedge clk); #1;
    check(busy == 1'b1, "R7 busy in reset", busy, 1);
    check(dout_en == 1'b0, "R7 bus released in reset", dout_en, 0);
    rst_n = 1'b1;
    wait_idle(1'b0, n, leaks);
    check(n == LOAD_SPAN, "R7 power-up restore length", n, LOAD_SPAN);
    check(leaks == 0, "R9 no standby during restore", leaks, 0);
    check(standby == 1'b1, "R9 standby when idle", standby, 1);
  endtask

  task automatic t_rw();
    fill(1'b0);
    sweep(1'b0, "R1 write then read");
    cyc(1'b0, 1'b1, 1'b1, 8'h10, 8'h00);
    check(dout_en == 1'b0, "R2 internal read keeps bus off", dout_en, 0);
    wr(8'h10, pat(16));
    check(dout_en == 1'b0, "R2 write keeps bus off", dout_en, 0);
    check(standby == 1'b0, "R9 selected is not standby", standby, 0);
    cyc(1'b1, 1'b0, 1'b1, 8'h10, 8'h55);
    rd(8'h10);
    check(dout == pat(16), "R2 deselected write has no effect", dout, pat(16));
  endtask

  task automatic t_save();
    int n, leaks;
    unlock(SAVE_A);
    check(busy == 1'b1 && dout_en == 1'b0, "R3 save starts after sixth read", busy, 1);
    wait_idle(1'b1, n, leaks);
    check(n == SAVE_SPAN, "R5 save length", n, SAVE_SPAN);
    check(leaks == 0, "R8 bus off while busy", leaks, 0);
    sweep(1'b0, "R8 writes during save ignored");
  endtask

  task automatic t_restore();
    int n, leaks;
    fill(1'b1);
    sweep(1'b1, "R1 overwrite visible");
    unlock(LOAD_A);
    check(busy == 1'b1, "R3 restore starts", busy, 1);
    wait_idle(1'b0, n, leaks);
    check(n == LOAD_SPAN, "R6 restore length", n, LOAD_SPAN);
    check(leaks == 0, "R9 ce high during restore not standby", leaks, 0);
    sweep(1'b0, "R6 restore brings back saved image");
  endtask

  task automatic t_abort();
    int n, leaks;
    // write in the middle
    for (int i = 0; i < 3; i++) rd(PFX[i]);
    wr(9, pat(9));
    rd(PFX[3]); rd(PFX[4]); rd(SAVE_A);
    check(busy == 1'b0, "R4 write aborts run", busy, 0);
    // foreign read in the middle
    for (int i = 0; i < 4; i++) rd(PFX[i]);
    rd(8'h00);
    rd(PFX[4]); rd(LOAD_A);
    check(busy == 1'b0, "R4 foreign read aborts run", busy, 0);
    // unknown selector
    unlock(8'h55);
    check(busy == 1'b0, "R4 unknown selector starts nothing", busy, 0);
    // deselected gaps keep progress
    rd(PFX[0]); rd(PFX[1]);
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    rd(PFX[2]); rd(PFX[3]); rd(PFX[4]);
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    rd(LOAD_A);
    check(busy == 1'b1, "R4 deselected cycles keep progress", busy, 1);
    wait_idle(1'b0, n, leaks);
    // restart on first entry
    rd(PFX[0]); rd(PFX[1]); rd(PFX[0]);
    rd(PFX[1]); rd(PFX[2]); rd(PFX[3]); rd(PFX[4]); rd(LOAD_A);
    check(busy == 1'b1, "R4 mismatch equal to first entry restarts", busy, 1);
    wait_idle(1'b0, n, leaks);
    check(n == LOAD_SPAN, "R6 repeated restore length", n, LOAD_SPAN);
    sweep(1'b0, "R4 aborted runs left data intact");
  endtask

  task automatic t_again();
    int n, leaks;
    for (int a = 0; a < 16; a++) wr(a, 8'h00);
    unlock(LOAD_A);
    wait_idle(1'b0, n, leaks);
    sweep(1'b0, "R6 shadow unchanged by restores");
  endtask

  initial begin
    t_reset();
    t_rw();
    t_save();
    t_restore();
    t_abort();
    t_again();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule